// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block is the programmable feedback divider of a fractional-N frequency synthesizer. It is clocked by the high-speed signal that is being divided. Once per division period it emits a one-clock pulse that the phase-frequency detector uses as its feedback input. The length of each period is an integer that changes from one period to the next. Over time the average ratio equals the integer setting plus a fraction, where the fraction is a numerator divided by a programmable modulus.

A three-stage cascade of modulo accumulators chooses each period's length. The accumulators wrap at the programmed modulus, which need not be a power of two. Their carries pass through a noise-shaping network that gives a signed offset from -3 to +4, and this offset is added to the integer setting. A loadable down-counter holds the resulting length. When the counter expires, the next length is taken from the modulator.

Software-visible settings arrive on three inputs with a load strobe. They are double-buffered, clamped to their legal ranges, and take effect only at a period boundary.

Top module: `fracn_fb_divider`

## Requirements
- R1: While reset is high the pulse output is low, all accumulator and delay state is cleared, and both the active and the pending setting take the clamped values present on the inputs. The first pulse appears in the cycle after the first rising edge at which reset is low.
- R2: Each pulse lasts exactly one clock cycle.
- R3: With a numerator of zero, every period lasts exactly the integer setting.
- R4: A period lasts INT + y clocks. The offset is y = c1 + c2 - c2' + c3 - 2*c3' + c3'', where ' marks the value of the previous step and '' the value two steps back, and y always lies in -3..+4. The length of the period that starts at a pulse is the value chosen at that pulse.
- R5: At each step every stage adds its input to its state. If the sum reaches the modulus or more, the modulus is subtracted and the carry is 1. Stage 1 adds the numerator, stage 2 adds the new value of stage 1, and stage 3 adds the new value of stage 2. Every state stays below the modulus.
- R6: Over the first MOD*k periods after the modulator is cleared, the total clock count is within 3 of k*(INT*MOD + FRAC).
- R7: A load strobe captures all three inputs as a pending set. The pending set becomes active at the next period boundary, so the period in progress keeps its length. A later strobe before that boundary replaces the pending set.
- R8: An integer setting below 31 is raised to 31. A modulus below 2 is raised to 2. A numerator above the clamped modulus is lowered to that modulus.
- R9: When a pending set becomes active, the accumulators and delay registers restart from zero, so the first step under the new set begins from a cleared state.
- R10: When the numerator equals the modulus, every period lasts exactly INT + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | High-speed clock being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| int_i | input | 9 | Integer part of the ratio, legal 31..511 |
| frac_i | input | 12 | Fraction numerator, legal 0..modulus |
| mod_i | input | 12 | Fraction modulus, legal 2..4095 |
| load_i | input | 1 | Captures the three setting inputs as a pending set |
| pulse_o | output | 1 | One-cycle feedback pulse, once per period |

## Verification
Several properties are checked on every cycle. Pulses never run longer than one clock. Each accumulator stays below the active modulus. Each loaded count lies within -3..+4 of the active integer. The active setting always stays legal, and it changes only at a period boundary, where it takes the pending value. What no single-cycle property can show is checked in the bench's scenarios. These cover the exact sequence of period lengths produced by the noise-shaping cascade, the long-run fractional average over a sweep of small moduli and every numerator, the restart of the modulator when a new set is applied, and the clamping of illegal settings.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int NSTAGE = 3;
    localparam int OFS_W  = 4;

    typedef logic signed [OFS_W-1:0] ofs_t;

    // Third-order difference network: c1 + (1-z^-1)c2 + (1-z^-1)^2 c3
    function automatic ofs_t shape_offset(
        input logic c1,
        input logic c2,
        input logic c2_p,
        input logic c3,
        input logic c3_p,
        input logic c3_pp
    );
        ofs_t r;
        r = ofs_t'({3'b000, c1})
          + ofs_t'({3'b000, c2})
          - ofs_t'({3'b000, c2_p})
          + ofs_t'({3'b000, c3})
          - ofs_t'({2'b00, c3_p, 1'b0})
          + ofs_t'({3'b000, c3_pp});
        return r;
    endfunction

endpackage

// File: rtl/fracn_cfg_bank.sv
module fracn_cfg_bank #(
    parameter int INT_W   = 9,
    parameter int MOD_W   = 12,
    parameter int INT_MIN = 31,
    parameter int MOD_MIN = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             boundary_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [MOD_W-1:0] frac_i,
    input  logic [MOD_W-1:0] mod_i,
    output logic [INT_W-1:0] use_int_o,
    output logic [MOD_W-1:0] use_frac_o,
    output logic [MOD_W-1:0] use_mod_o,
    output logic [INT_W-1:0] act_int_o,
    output logic [MOD_W-1:0] act_mod_o,
    output logic             apply_o
);

    typedef struct packed {
        logic [INT_W-1:0] ival;
        logic [MOD_W-1:0] fval;
        logic [MOD_W-1:0] mval;
    } cfg_t;

    typedef struct packed {
        cfg_t act;
        cfg_t shd;
        logic pend;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cin;

    // R8: clamp at capture
    always_comb begin
        cin.mval = (mod_i < MOD_W'(MOD_MIN)) ? MOD_W'(MOD_MIN) : mod_i;
        cin.fval = (frac_i > cin.mval) ? cin.mval : frac_i;
        cin.ival = (int_i < INT_W'(INT_MIN)) ? INT_W'(INT_MIN) : int_i;
    end

    always_comb begin
        st_d = st_q;
        if (boundary_i && st_q.pend) begin
            st_d.act  = st_q.shd;
            st_d.pend = 1'b0;
        end
        if (load_i) begin
            st_d.shd  = cin;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.act  <= cin;
            st_q.shd  <= cin;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        use_int_o  = st_q.pend ? st_q.shd.ival : st_q.act.ival;
        use_frac_o = st_q.pend ? st_q.shd.fval : st_q.act.fval;
        use_mod_o  = st_q.pend ? st_q.shd.mval : st_q.act.mval;
        act_int_o  = st_q.act.ival;
        act_mod_o  = st_q.act.mval;
        apply_o    = st_q.pend && boundary_i;
    end

    assert_active_legal_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.act.ival >= INT_W'(INT_MIN)) && (st_q.act.mval >= MOD_W'(MOD_MIN))
        && (st_q.act.fval <= st_q.act.mval));

    assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !boundary_i |=> $stable(st_q.act));

    assert_apply_pending_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (boundary_i && st_q.pend) |=> (st_q.act == $past(st_q.shd)));

    assert_load_pends_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> st_q.pend);

endmodule

// File: rtl/fracn_mod_stage.sv
module fracn_mod_stage #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         step_i,
    input  logic         clear_i,
    input  logic [W-1:0] add_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] acc_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] acc;
    } st_t;

    st_t        st_d, st_q;
    logic [W:0] base;
    logic [W:0] total;

    // R5: modulo-MOD add with one-bit carry
    always_comb begin
        base    = clear_i ? '0 : {1'b0, st_q.acc};
        total   = base + {1'b0, add_i};
        carry_o = (total >= {1'b0, mod_i});
        sum_o   = carry_o ? (total[W-1:0] - mod_i) : total[W-1:0];
        st_d    = st_q;
        if (step_i) begin
            st_d.acc = sum_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/fracn_noise_shaper.sv
module fracn_noise_shaper
    import fracn_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic              clear_i,
    input  logic [NSTAGE-1:0] carry_i,
    output ofs_t              offset_o
);

    typedef struct packed {
        logic c2_p;
        logic c3_p;
        logic c3_pp;
    } st_t;

    st_t  st_d, st_q;
    logic p2, p3, p33;

    always_comb begin
        p2       = clear_i ? 1'b0 : st_q.c2_p;
        p3       = clear_i ? 1'b0 : st_q.c3_p;
        p33      = clear_i ? 1'b0 : st_q.c3_pp;
        offset_o = shape_offset(carry_i[0], carry_i[1], p2, carry_i[2], p3, p33);
        st_d     = st_q;
        if (step_i) begin
            st_d.c2_p  = carry_i[1];
            st_d.c3_p  = carry_i[2];
            st_d.c3_pp = p3;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
    import fracn_pkg::*;
#(
    parameter int INT_W   = 9,
    parameter int MOD_W   = 12,
    parameter int INT_MIN = 31,
    parameter int MOD_MIN = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [INT_W-1:0] int_i,
    input  logic [MOD_W-1:0] frac_i,
    input  logic [MOD_W-1:0] mod_i,
    input  logic             load_i,
    output logic             pulse_o
);

    localparam int CNT_W = INT_W + 1;
    localparam int AW    = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } st_t;

    st_t st_d, st_q;

    logic                         expire;
    logic                         apply;
    logic [INT_W-1:0]             use_int, act_int;
    logic [MOD_W-1:0]             use_frac, use_mod, act_mod;
    logic [NSTAGE:0][MOD_W-1:0]   chain;
    logic [NSTAGE-1:0][MOD_W-1:0] accs;
    logic [NSTAGE-1:0]            carries;
    ofs_t                         offset;
    logic [CNT_W-1:0]             off_ext;
    logic [CNT_W-1:0]             nval;

    assign expire = (st_q.cnt == '0);

    fracn_cfg_bank #(
        .INT_W   (INT_W),
        .MOD_W   (MOD_W),
        .INT_MIN (INT_MIN),
        .MOD_MIN (MOD_MIN)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load_i),
        .boundary_i (expire),
        .int_i      (int_i),
        .frac_i     (frac_i),
        .mod_i      (mod_i),
        .use_int_o  (use_int),
        .use_frac_o (use_frac),
        .use_mod_o  (use_mod),
        .act_int_o  (act_int),
        .act_mod_o  (act_mod),
        .apply_o    (apply)
    );

    assign chain[0] = use_frac;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        fracn_mod_stage #(
            .W (MOD_W)
        ) u_stage (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .step_i  (expire),
            .clear_i (apply),
            .add_i   (chain[g]),
            .mod_i   (use_mod),
            .sum_o   (chain[g+1]),
            .acc_o   (accs[g]),
            .carry_o (carries[g])
        );

        assert_acc_below_mod_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            accs[g] < act_mod);
    end

    fracn_noise_shaper u_shaper (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_i   (expire),
        .clear_i  (apply),
        .carry_i  (carries),
        .offset_o (offset)
    );

    // R4: next period length = INT + offset, held in a down-counter
    always_comb begin
        off_ext   = {{(CNT_W-OFS_W){offset[OFS_W-1]}}, offset};
        nval      = {1'b0, use_int} + off_ext;
        st_d      = st_q;
        st_d.pulse = expire;
        if (expire) begin
            st_d.cnt = nval - CNT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    logic [AW-1:0] cnt_w, int_w;
    assign cnt_w = {1'b0, st_q.cnt};
    assign int_w = {2'b00, act_int};

    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    assert_period_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> ((cnt_w + AW'(4) >= int_w) && (cnt_w <= int_w + AW'(3))));

endmodule

// File: tb/fracn_fb_divider_bench.sv
`timescale 1ns/1ps
module fracn_fb_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [8:0]  int_v = 9'd40;
    logic [11:0] frac_v = 12'd0;
    logic [11:0] mod_v = 12'd7;
    logic        pulse;

    always #2 clk = ~clk;

    fracn_fb_divider u_fracn_fb_divider (
        .clk_i   (clk),
        .rst_i   (rst),
        .int_i   (int_v),
        .frac_i  (frac_v),
        .mod_i   (mod_v),
        .load_i  (load),
        .pulse_o (pulse)
    );

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;

    // independent reference of the requirements
    int     m_int, m_frac, m_mod;
    int     p_int, p_frac, p_mod;
    int     a1, a2, a3, c2p, c3p, c3pp;
    bit     pend_m;
    int     exp_n;
    longint t_prev;
    bit     have_prev;
    longint win_sum;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void clamp3(input int i, input int f, input int m,
                                   output int oi, output int of, output int om);
        om = (m < 2) ? 2 : m;
        of = (f > om) ? om : f;
        oi = (i < 31) ? 31 : i;
    endfunction

    function automatic void zero_model();
        a1 = 0; a2 = 0; a3 = 0; c2p = 0; c3p = 0; c3pp = 0;
    endfunction

    function automatic int model_step();
        int c1, c2, c3, o;
        a1 = a1 + m_frac; c1 = (a1 >= m_mod) ? 1 : 0; if (c1 == 1) a1 = a1 - m_mod;
        a2 = a2 + a1;     c2 = (a2 >= m_mod) ? 1 : 0; if (c2 == 1) a2 = a2 - m_mod;
        a3 = a3 + a2;     c3 = (a3 >= m_mod) ? 1 : 0; if (c3 == 1) a3 = a3 - m_mod;
        o = c1 + c2 - c2p + c3 - 2 * c3p + c3pp;
        c3pp = c3p; c3p = c3; c2p = c2;
        return m_int + o;
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic wait_pulse(output longint t);
        int n = 0;
        do begin
            tick();
            n++;
        end while (!pulse && n < 5000);
        t = cyc;
    endtask

    task automatic run(input int n, input string req, input bit add_sum);
        longint t;
        for (int k = 0; k < n; k++) begin
            wait_pulse(t);
            if (have_prev) begin
                check((t - t_prev) == exp_n, req, t - t_prev, exp_n);
                if (add_sum) win_sum += t - t_prev;
            end
            if (pend_m) begin
                m_int = p_int; m_frac = p_frac; m_mod = p_mod;
                zero_model();
                pend_m = 0;
            end
            exp_n     = model_step();
            t_prev    = t;
            have_prev = 1;
        end
    endtask

    task automatic do_load(input int i, input int f, input int m);
        int ci, cf, cm;
        int_v  = 9'(i);
        frac_v = 12'(f);
        mod_v  = 12'(m);
        load   = 1'b1;
        tick();
        load   = 1'b0;
        clamp3(i, f, m, ci, cf, cm);
        p_int = ci; p_frac = cf; p_mod = cm;
        pend_m = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        longint t_rel;
        // R1: reset state
        for (int k = 0; k < 5; k++) begin
            tick();
            check(pulse == 1'b0, "R1 pulse low in reset", longint'(pulse), 0);
        end
        rst = 1'b0;
        clamp3(40, 0, 7, m_int, m_frac, m_mod);
        zero_model();
        pend_m = 0;
        have_prev = 0;
        t_rel = cyc;
        run(1, "R1", 1'b0);
        check((t_prev - t_rel) == 1, "R1 first pulse timing", t_prev - t_rel, 1);
        tick();
        check(pulse == 1'b0, "R2 pulse width one cycle", longint'(pulse), 0);
        run(20, "R3 integer-only periods", 1'b0);

        // R7: second strobe overwrites pending set; period in progress unchanged
        do_load(100, 3, 9);
        do_load(50, 1, 4);
        run(1, "R7 period in progress keeps old length", 1'b0);
        run(12, "R9 restart from cleared modulator", 1'b0);

        // R5: modulo wrap with a non-power-of-two modulus
        do_load(60, 2, 3);
        run(1, "R7", 1'b0);
        run(15, "R5 modulo accumulation", 1'b0);

        // Sweep of small moduli and every numerator: R4, R6, R3, R10
        for (int m = 2; m <= 7; m++) begin
            for (int f = 0; f <= m; f++) begin
                longint want;
                longint diff;
                do_load(31, f, m);
                run(1, "R7", 1'b0);
                win_sum = 0;
                if (f == 0)      run(4 * m, "R3", 1'b1);
                else if (f == m) run(4 * m, "R10", 1'b1);
                else             run(4 * m, "R4", 1'b1);
                want = 4 * (31 * m + f);
                diff = win_sum - want;
                if (diff < 0) diff = -diff;
                check(diff <= 3, "R6 average over MOD*k periods", win_sum, want);
            end
        end

        // Wide settings
        do_load(200, 5, 4095);
        run(1, "R7", 1'b0);
        run(30, "R4 large modulus", 1'b0);
        do_load(511, 4095, 4095);
        run(1, "R7", 1'b0);
        run(5, "R10 top of range", 1'b0);

        // R8: clamping
        do_load(5, 3, 1);
        run(1, "R7", 1'b0);
        run(6, "R8 clamp int/mod/frac", 1'b0);
        do_load(0, 0, 0);
        run(1, "R7", 1'b0);
        run(6, "R8 clamp all-zero", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule